// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This unit carries out one atomic memory instruction at a time against a synchronous memory port with a request/ready handshake. A pipeline hands it the opcode, the 32-bit immediate, the signed 16-bit offset and three register values: the base address register, the source register and register zero. The unit computes the address and reads the memory word under a bus lock. It works out the new value and writes it back unless a compare-exchange misses. Then it raises a one-cycle completion strobe. The strobe carries an optional register write-back, which goes either to the source register or to register zero.

The immediate's low byte selects the operation. Bit 0 of that byte is a fetch modifier, and it asks for the old memory value to be returned. Two operand widths exist: a 32-bit word and a 64-bit double word. An encoding the unit does not support raises a one-cycle illegal strobe and makes no memory access.

Top module: `amo_unit`

## Requirements
- R1: An instruction is accepted only for opcode 0xC3 (word) or 0xDB (double word). Any other opcode gives an illegal pulse one cycle after `start`, makes no memory request and returns no write-back.
- R2: The memory address is the base register value plus the 16-bit offset, with the offset sign-extended.
- R3: Immediate low byte 0x00 adds, 0x40 ORs, 0x50 ANDs and 0xA0 XORs the source value into the memory value, and the result is written back to memory.
- R4: Immediate bit 0 (fetch) makes the completion cycle return the pre-operation memory value with `wb_en`=1 and `wb_to_r0`=0. Without fetch, `wb_en` stays 0.
- R5: Immediate 0xE1 (exchange) writes the source value to memory and returns the old value to the source register.
- R6: Immediate 0xF1 (compare-exchange) writes the source value only when the old memory value equals the register-zero value. In either case it returns the old value with `wb_en`=1 and `wb_to_r0`=1. On a mismatch no write request is issued.
- R7: Immediates 0xE0 and 0xF0, any other low-byte code, and any non-zero bit in imm[31:8] are illegal and behave as in R1.
- R8: In word mode `mem_wide`=0 and data travels on bits [31:0]. Compare and arithmetic use only those bits, written data has zero upper bits, and the returned value is zero-extended to 64 bits.
- R9: `mem_lock` is high whenever a request is outstanding and stays high without a gap from the read request until the write completes. It falls only when entering the completion cycle.
- R10: Each instruction performs a read, then at most one write, then a one-cycle `done`, after which the unit is idle. `start` is ignored while `busy` is high. A request held without `mem_ready` keeps its address and direction stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Issue the presented instruction (taken only when idle) |
| opcode | input | 8 | Instruction opcode |
| imm | input | 32 | Immediate carrying the operation code |
| offset | input | 16 | Signed address offset |
| base_val | input | 64 | Base address register value |
| src_val | input | 64 | Source register value |
| r0_val | input | 64 | Register zero value (compare operand) |
| busy | output | 1 | Instruction in progress |
| illegal | output | 1 | One-cycle pulse for an unsupported encoding |
| done | output | 1 | One-cycle completion strobe |
| wb_en | output | 1 | Register write-back valid during `done` |
| wb_to_r0 | output | 1 | Write-back targets register zero instead of the source register |
| wb_data | output | 64 | Write-back value |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_wide | output | 1 | 1 = 64-bit access, 0 = 32-bit access |
| mem_lock | output | 1 | Bus lock for the whole read-modify-write |
| mem_addr | output | 64 | Access address |
| mem_wdata | output | 64 | Write data |
| mem_ready | input | 1 | Request accepted this cycle |
| mem_rdata | input | 64 | Read data, valid when a read is accepted |

## Verification
Two things can land in the same cycle: a new `start` and an instruction already in flight. To provoke this, the bench raises `start` with an illegal opcode while a legal operation is still busy. It then checks that no illegal pulse and no extra completion come out, and that the first operation's memory result and write-back stay intact. The other pairing is the write-back and the compare outcome at completion. In a compare-exchange the value returned to register zero must be the old memory word, whether or not the write was suppressed. The scoreboard judges both outcomes against the bench's own memory model.

// File: rtl/amo_pkg.sv
package amo_pkg;

    // Opcode fields
    localparam logic [2:0] CLS_STORE_REG = 3'h3;
    localparam logic [2:0] MODE_ATOMIC   = 3'h6;
    localparam logic [1:0] SZ_WORD       = 2'b00;
    localparam logic [1:0] SZ_DWORD      = 2'b11;

    // Immediate operation codes (fetch bit cleared)
    localparam logic [7:0] IOP_ADD  = 8'h00;
    localparam logic [7:0] IOP_OR   = 8'h40;
    localparam logic [7:0] IOP_AND  = 8'h50;
    localparam logic [7:0] IOP_XOR  = 8'hA0;
    localparam logic [7:0] IOP_SWAP = 8'hE0;
    localparam logic [7:0] IOP_CAS  = 8'hF0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_CALC,
        ST_WRITE,
        ST_RESP
    } amo_state_t;

    typedef enum logic [2:0] {
        K_ADD,
        K_OR,
        K_AND,
        K_XOR,
        K_SWAP,
        K_CAS
    } amo_kind_t;

    typedef struct packed {
        amo_kind_t kind;
        logic      fetch;
        logic      wide;
        logic      legal;
    } amo_ctl_t;

    function automatic logic [63:0] narrow64(input logic [63:0] v, input logic wide);
        return wide ? v : {32'b0, v[31:0]};
    endfunction

endpackage

// File: rtl/amo_decode.sv
module amo_decode
    import amo_pkg::*;
#(
    parameter int IMM_W = 32
) (
    input  logic [7:0]       opcode,
    input  logic [IMM_W-1:0] imm,
    output amo_ctl_t         ctl
);
    localparam int HI_W = IMM_W - 8;

    logic       cls_ok;
    logic       mode_ok;
    logic       size_ok;
    logic       hi_zero;
    logic [7:0] base_code;
    logic       code_ok;
    amo_kind_t  kind;

    always_comb begin
        cls_ok    = (opcode[2:0] == CLS_STORE_REG);
        mode_ok   = (opcode[7:5] == MODE_ATOMIC);
        size_ok   = (opcode[4:3] == SZ_WORD) || (opcode[4:3] == SZ_DWORD);
        hi_zero   = (imm[IMM_W-1:8] == {HI_W{1'b0}});
        base_code = {imm[7:1], 1'b0};
        code_ok   = 1'b1;
        kind      = K_ADD;
        unique case (base_code)
            IOP_ADD:  kind = K_ADD;
            IOP_OR:   kind = K_OR;
            IOP_AND:  kind = K_AND;
            IOP_XOR:  kind = K_XOR;
            IOP_SWAP: begin kind = K_SWAP; code_ok = imm[0]; end
            IOP_CAS:  begin kind = K_CAS;  code_ok = imm[0]; end
            default:  code_ok = 1'b0;
        endcase
        ctl.kind  = kind;
        ctl.fetch = imm[0];
        ctl.wide  = (opcode[4:3] == SZ_DWORD);
        ctl.legal = cls_ok && mode_ok && size_ok && hi_zero && code_ok;
    end

endmodule

// File: rtl/amo_agu.sv
module amo_agu #(
    parameter int ADDR_W = 64,
    parameter int OFF_W  = 16
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [OFF_W-1:0]  off,
    output logic [ADDR_W-1:0] addr
);
    localparam int EXT_W = ADDR_W - OFF_W;

    assign addr = base + {{EXT_W{off[OFF_W-1]}}, off};

endmodule

// File: rtl/amo_alu.sv
module amo_alu
    import amo_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  amo_ctl_t          ctl,
    input  logic [DATA_W-1:0] old_v,
    input  logic [DATA_W-1:0] src_v,
    input  logic [DATA_W-1:0] cmp_v,
    output logic [DATA_W-1:0] new_v,
    output logic              match
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] a;
    logic [DATA_W-1:0] b;
    logic [DATA_W-1:0] c;
    logic [DATA_W-1:0] r;

    always_comb begin
        a = ctl.wide ? old_v : {{HALF_W{1'b0}}, old_v[HALF_W-1:0]};
        b = ctl.wide ? src_v : {{HALF_W{1'b0}}, src_v[HALF_W-1:0]};
        c = ctl.wide ? cmp_v : {{HALF_W{1'b0}}, cmp_v[HALF_W-1:0]};
        unique case (ctl.kind)
            K_ADD:   r = a + b;
            K_OR:    r = a | b;
            K_AND:   r = a & b;
            K_XOR:   r = a ^ b;
            default: r = b;
        endcase
        match = (a == c);
        new_v = ctl.wide ? r : {{HALF_W{1'b0}}, r[HALF_W-1:0]};
    end

endmodule

// File: rtl/amo_unit.sv
module amo_unit
    import amo_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 64,
    parameter int OFF_W  = 16,
    parameter int IMM_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [7:0]        opcode,
    input  logic [IMM_W-1:0]  imm,
    input  logic [OFF_W-1:0]  offset,
    input  logic [ADDR_W-1:0] base_val,
    input  logic [DATA_W-1:0] src_val,
    input  logic [DATA_W-1:0] r0_val,
    output logic              busy,
    output logic              illegal,
    output logic              done,
    output logic              wb_en,
    output logic              wb_to_r0,
    output logic [DATA_W-1:0] wb_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_wide,
    output logic              mem_lock,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int HALF_W = DATA_W / 2;

    amo_state_t        state;
    amo_ctl_t          dec_ctl;
    amo_ctl_t          ctl_q;
    logic [ADDR_W-1:0] agu_addr;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] src_q;
    logic [DATA_W-1:0] cmp_q;
    logic [DATA_W-1:0] old_q;
    logic [DATA_W-1:0] new_q;
    logic [DATA_W-1:0] alu_new;
    logic              alu_match;
    logic              ill_q;

    amo_decode #(.IMM_W(IMM_W)) u_dec (
        .opcode (opcode),
        .imm    (imm),
        .ctl    (dec_ctl)
    );

    amo_agu #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_agu (
        .base (base_val),
        .off  (offset),
        .addr (agu_addr)
    );

    amo_alu #(.DATA_W(DATA_W)) u_alu (
        .ctl   (ctl_q),
        .old_v (old_q),
        .src_v (src_q),
        .cmp_v (cmp_q),
        .new_v (alu_new),
        .match (alu_match)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            ctl_q  <= '0;
            addr_q <= '0;
            src_q  <= '0;
            cmp_q  <= '0;
            old_q  <= '0;
            new_q  <= '0;
            ill_q  <= 1'b0;
        end else begin
            ill_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (dec_ctl.legal) begin
                            ctl_q  <= dec_ctl;
                            addr_q <= agu_addr;
                            src_q  <= src_val;
                            cmp_q  <= r0_val;
                            state  <= ST_READ;
                        end else begin
                            ill_q <= 1'b1;
                        end
                    end
                end
                ST_READ: begin
                    if (mem_ready) begin
                        old_q <= ctl_q.wide ? mem_rdata
                                            : {{HALF_W{1'b0}}, mem_rdata[HALF_W-1:0]};
                        state <= ST_CALC;
                    end
                end
                ST_CALC: begin
                    new_q <= alu_new;
                    if (ctl_q.kind == K_CAS && !alu_match) begin
                        state <= ST_RESP;
                    end else begin
                        state <= ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    if (mem_ready) begin
                        state <= ST_RESP;
                    end
                end
                ST_RESP: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy      = (state != ST_IDLE);
        illegal   = ill_q;
        done      = (state == ST_RESP);
        wb_en     = done && ctl_q.fetch;
        wb_to_r0  = done && (ctl_q.kind == K_CAS);
        wb_data   = done ? old_q : '0;
        mem_req   = (state == ST_READ) || (state == ST_WRITE);
        mem_we    = (state == ST_WRITE);
        mem_wide  = ctl_q.wide;
        mem_lock  = (state == ST_READ) || (state == ST_CALC) || (state == ST_WRITE);
        mem_addr  = addr_q;
        mem_wdata = new_q;
    end

endmodule

// File: rtl/amo_unit_chk.sv
module amo_unit_chk #(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              illegal,
    input logic              done,
    input logic              wb_en,
    input logic              wb_to_r0,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_wide,
    input logic              mem_lock,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata
);
    localparam int HALF_W = DATA_W / 2;

    // R9
    req_locked_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> mem_lock);

    // R9
    lock_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_lock) |-> done);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done && !busy);

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R1
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        illegal |-> !mem_req && !busy && !done);

    // R6
    r0_target_chk: assert property (@(posedge clk) disable iff (rst)
        wb_to_r0 |-> wb_en && done);

    // R8
    narrow_wdata_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we && !mem_wide |-> mem_wdata[DATA_W-1:HALF_W] == '0);

endmodule

bind amo_unit amo_unit_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .illegal   (illegal),
    .done      (done),
    .wb_en     (wb_en),
    .wb_to_r0  (wb_to_r0),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_wide  (mem_wide),
    .mem_lock  (mem_lock),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
);

// File: tb/amo_unit_test.sv
module amo_unit_test;

    typedef struct {
        bit          ill;
        bit          wen;
        bit          tor0;
        logic [63:0] wdata;
        logic [63:0] addr;
        logic [63:0] memv;
        bit          wr;
        bit          wide;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  opcode = '0;
    logic [31:0] imm = '0;
    logic [15:0] offset = '0;
    logic [63:0] base_val = '0, src_val = '0, r0_val = '0;
    logic        busy, illegal, done, wb_en, wb_to_r0;
    logic [63:0] wb_data;
    logic        mem_req, mem_we, mem_wide, mem_lock;
    logic [63:0] mem_addr, mem_wdata;
    logic        mem_ready = 1'b0;
    logic [63:0] mem_rdata;

    logic [63:0] mem [8];
    int          n_req = 0, n_wr = 0;
    logic [63:0] seen_addr = '0;
    bit          seen_wide = 0;
    exp_t        q[$];
    int          issued = 0, resolved = 0;
    int          checks = 0, fails = 0;

    always #4 clk = ~clk;

    amo_unit uut (
        .clk(clk), .rst(rst), .start(start), .opcode(opcode), .imm(imm),
        .offset(offset), .base_val(base_val), .src_val(src_val), .r0_val(r0_val),
        .busy(busy), .illegal(illegal), .done(done), .wb_en(wb_en),
        .wb_to_r0(wb_to_r0), .wb_data(wb_data), .mem_req(mem_req), .mem_we(mem_we),
        .mem_wide(mem_wide), .mem_lock(mem_lock), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
    );

    // Memory model: one wait cycle per request, dword array by addr[5:3]
    always_comb begin
        if (mem_wide) mem_rdata = mem[mem_addr[5:3]];
        else if (mem_addr[2]) mem_rdata = {32'b0, mem[mem_addr[5:3]][63:32]};
        else mem_rdata = {32'b0, mem[mem_addr[5:3]][31:0]};
    end

    always @(posedge clk) begin
        mem_ready <= mem_req && !mem_ready;
        if (mem_req && mem_ready) begin
            n_req     <= n_req + 1;
            seen_addr <= mem_addr;
            seen_wide <= mem_wide;
            if (mem_we) begin
                n_wr <= n_wr + 1;
                if (mem_wide) mem[mem_addr[5:3]] <= mem_wdata;
                else if (mem_addr[2]) mem[mem_addr[5:3]][63:32] <= mem_wdata[31:0];
                else mem[mem_addr[5:3]][31:0] <= mem_wdata[31:0];
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic exp_t model(input logic [7:0] opc, input logic [31:0] im,
                                   input logic [63:0] bv, input logic [15:0] off,
                                   input logic [63:0] sv, input logic [63:0] rv,
                                   input string tag);
        exp_t e;
        logic [63:0] word, old, s, r, nv;
        bit legal, wide, fetch, cas, ok_code;
        e.tag  = tag;
        e.addr = bv + {{48{off[15]}}, off};
        wide   = (opc == 8'hDB);
        legal  = (opc == 8'hDB) || (opc == 8'hC3);
        fetch  = im[0];
        cas    = 0;
        ok_code = (im[31:8] == 0);
        word   = mem[e.addr[5:3]];
        old    = wide ? word : (e.addr[2] ? {32'b0, word[63:32]} : {32'b0, word[31:0]});
        s      = wide ? sv : {32'b0, sv[31:0]};
        r      = wide ? rv : {32'b0, rv[31:0]};
        nv     = s;
        case (im[7:0] & 8'hFE)
            8'h00: nv = old + s;
            8'h40: nv = old | s;
            8'h50: nv = old & s;
            8'hA0: nv = old ^ s;
            8'hE0: ok_code = ok_code && fetch;
            8'hF0: begin ok_code = ok_code && fetch; cas = 1; end
            default: ok_code = 0;
        endcase
        if (!wide) nv = {32'b0, nv[31:0]};
        e.ill  = !(legal && ok_code);
        e.wide = wide;
        e.wr   = !e.ill && !(cas && old != r);
        e.wen  = !e.ill && fetch;
        e.tor0 = !e.ill && cas;
        e.wdata = e.wen ? old : 64'h0;
        e.memv = word;
        if (e.wr) begin
            if (wide) e.memv = nv;
            else if (e.addr[2]) e.memv[63:32] = nv[31:0];
            else e.memv[31:0] = nv[31:0];
        end
        return e;
    endfunction

    // Monitor
    always @(negedge clk) begin
        if (!rst && (done || illegal)) begin
            if (q.size() == 0) begin
                check(0, "R10 unexpected event", {62'b0, done, illegal}, 64'h0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(illegal == e.ill && done == !e.ill, {e.tag, " R1/R7 outcome"},
                      {63'b0, illegal}, {63'b0, e.ill});
                check(wb_en == e.wen, {e.tag, " R4 wb_en"}, {63'b0, wb_en}, {63'b0, e.wen});
                check(wb_to_r0 == e.tor0, {e.tag, " R6 wb_to_r0"},
                      {63'b0, wb_to_r0}, {63'b0, e.tor0});
                if (e.wen) check(wb_data == e.wdata, {e.tag, " R4 wb_data"}, wb_data, e.wdata);
                if (e.ill) begin
                    check(n_req == 0, {e.tag, " R1 no access"}, n_req, 0);
                end else begin
                    check(seen_addr == e.addr, {e.tag, " R2 address"}, seen_addr, e.addr);
                    check(seen_wide == e.wide, {e.tag, " R8 width"},
                          {63'b0, seen_wide}, {63'b0, e.wide});
                    check(n_wr == int'(e.wr), {e.tag, " R10 write count"}, n_wr, e.wr);
                    check(n_req == 1 + int'(e.wr), {e.tag, " R10 request count"},
                          n_req, 1 + int'(e.wr));
                    check(mem[e.addr[5:3]] == e.memv, {e.tag, " R3 memory"},
                          mem[e.addr[5:3]], e.memv);
                end
            end
            resolved++;
        end
    end

    task automatic issue(input logic [7:0] opc, input logic [31:0] im,
                         input logic [63:0] bv, input logic [15:0] off,
                         input logic [63:0] sv, input logic [63:0] rv,
                         input string tag, input bit poke_busy);
        @(negedge clk);
        n_req = 0;
        n_wr  = 0;
        q.push_back(model(opc, im, bv, off, sv, rv, tag));
        issued++;
        opcode = opc; imm = im; base_val = bv; offset = off; src_val = sv; r0_val = rv;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke_busy) begin
            // R10: start with an illegal opcode while busy must be ignored
            @(negedge clk);
            opcode = 8'h00; imm = 32'hE0; base_val = '0; src_val = '1;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (resolved < issued) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        check(0, "watchdog", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) mem[i] = 64'h1111_0000_0000_0000 * (i + 1) + 64'h0123_4567;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check(!busy && !mem_req && !done && !illegal && !mem_lock, "R10 reset state",
              {59'b0, busy, mem_req, done, illegal, mem_lock}, 64'h0);

        issue(8'hDB, 32'h00, 64'h100, 16'h0008, 64'h5, 64'h0, "R3 add64", 0);
        issue(8'hDB, 32'h41, 64'h120, 16'hFFF8, 64'hF0F0, 64'h0, "R4 or64 fetch negoff", 0);
        issue(8'hC3, 32'h51, 64'h104, 16'h0010, 64'hFFFF_FFFF_00FF_00FF, 64'h0, "R8 and32 hi", 0);
        issue(8'hC3, 32'hA0, 64'h100, 16'h0020, 64'hDEAD_BEEF_0F0F_0F0F, 64'h0, "R3 xor32 lo", 0);
        mem[6] = 64'h7777_7777_FFFF_FFFF;
        issue(8'hC3, 32'h01, 64'h130, 16'h0000, 64'h1, 64'h0, "R8 add32 wrap", 0);
        issue(8'hDB, 32'hE1, 64'h108, 16'h0000, 64'hCAFE_F00D_1234_5678, 64'h0, "R5 xchg64", 0);
        issue(8'hDB, 32'hF1, 64'h100, 16'h0008, 64'h55, 64'hCAFE_F00D_1234_5678, "R6 cas64 hit", 0);
        issue(8'hC3, 32'hF1, 64'h100, 16'h0000, 64'h99, 64'h1234, "R6 cas32 miss", 0);
        issue(8'hC3, 32'hF1, 64'h100, 16'h0000, 64'h99, 64'hFFFF_FFFF_0123_4567, "R6 cas32 hit", 0);
        issue(8'hD3, 32'h00, 64'h100, 16'h0000, 64'h1, 64'h0, "R1 byte size", 0);
        issue(8'hDA, 32'h00, 64'h100, 16'h0000, 64'h1, 64'h0, "R1 wrong class", 0);
        issue(8'hDB, 32'hE0, 64'h100, 16'h0000, 64'h1, 64'h0, "R7 xchg nofetch", 0);
        issue(8'hDB, 32'hF0, 64'h100, 16'h0000, 64'h1, 64'h0, "R7 cas nofetch", 0);
        issue(8'hDB, 32'h10, 64'h100, 16'h0000, 64'h1, 64'h0, "R7 bad code", 0);
        issue(8'hDB, 32'h100, 64'h100, 16'h0000, 64'h1, 64'h0, "R7 high imm", 0);
        issue(8'hDB, 32'hA1, 64'h110, 16'h0000, 64'hFF, 64'h0, "R10 start while busy", 1);
        // R9: lock stays clear when idle
        check(!mem_lock && !busy, "R9 idle lock", {62'b0, mem_lock, busy}, 64'h0);
        check(resolved == issued, "R10 event count", resolved, issued);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule